// File: doc/BRIEF.md
# Vulnerability-Ranked Floating-Point Pipeline Allocator

This block hands out one of several shared floating-point pipelines to each operation request. Every pipeline has a characterised vulnerability value for each operation type, such as multiply or add, taken from a table input. The block turns each operation type's column of that table into an ascending order of pipelines. When a request arrives, the block walks that order from the least to the most error-prone pipeline and grants the first one that is free and allowed to take the request.

A request is marked either exact or approximate. An approximate request carries a count of low fraction bits whose timing errors may go uncorrected. Such a request may only land on a pipeline whose vulnerability is below a programmable error-rate threshold. On a grant the block writes the chosen pipeline's operating mode and its sensing mask. The mask has one bit per single-precision fraction bit, and a set bit switches timing-error detection off on that bit. If nothing qualifies, the block raises a stall and the requester holds its request for the next cycle.

The arithmetic is outside this block. Each pipeline appears here only as a busy flag, which a grant sets and the pipeline's done pulse clears, and as its mode and mask registers.

Top module: `fpa_alloc`

## Requirements
- R1: While reset is asserted and after it is released, every pipeline is free, in exact mode, with an all-zero mask, and no grant or stall is raised until a request arrives.
- R2: An approximate request is granted only to a pipeline whose vulnerability for the requested operation type is strictly less than `err_thr_i`.
- R3: The vulnerability of operation type o on pipeline p is `vuln_tab_i[(o*NUM_PIPES+p)*VULN_W +: VULN_W]`. The grant goes to the qualifying pipeline with the lowest vulnerability for the requested type, and a tie goes to the lower pipeline index. Each operation type has its own order.
- R4: A busy pipeline is never granted, whatever its rank.
- R5: When a request is valid and no pipeline qualifies, `stall_o` is high and `grant_o` is low in that cycle, and no busy flag, mode or mask changes.
- R6: On an approximate grant, the chosen pipeline's mode becomes approximate (`cfg_approx_o` bit = 1) from the next cycle. Its mask (`cfg_mask_o[p*FRAC_W +: FRAC_W]`) has bit i set exactly when i < min(`req_sig_i`, 23), so counts from 24 to 31 give all 23 bits.
- R7: On an exact grant, the chosen pipeline's mode becomes exact (0) and its mask becomes all zeros from the next cycle.
- R8: A grant sets the pipeline's busy flag from the next cycle. A done pulse on a busy pipeline clears it from the next cycle. A done pulse on a free pipeline has no effect. Mode and mask hold until the next grant to that pipeline.
- R9: A pipeline whose done pulse comes in the same cycle as a request is still treated as busy in that cycle and becomes grantable in the following cycle.
- R10: With no valid request, neither grant nor stall is raised and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; held by the requester while stalled |
| req_op_i | input | OP_W | Operation type index |
| req_approx_i | input | 1 | 1 = approximate request, 0 = exact |
| req_sig_i | input | 5 | Count of low fraction bits with sensing off (approximate only) |
| err_thr_i | input | VULN_W | Error-rate threshold for approximate requests |
| vuln_tab_i | input | NUM_OPS*NUM_PIPES*VULN_W | Vulnerability table, layout per R3 |
| done_i | input | NUM_PIPES | Per-pipeline completion pulse |
| grant_o | output | 1 | A pipeline is granted this cycle |
| grant_pipe_o | output | PIPE_W | Index of the granted pipeline |
| stall_o | output | 1 | Request valid but nothing qualifies |
| busy_o | output | NUM_PIPES | Per-pipeline busy flags |
| cfg_approx_o | output | NUM_PIPES | Per-pipeline mode, 1 = approximate |
| cfg_mask_o | output | NUM_PIPES*FRAC_W | Per-pipeline sensing-off masks |

## Verification
Two things can land on the same pipeline in one cycle: a done pulse that releases it and a new request that would prefer it. The bench provokes this on purpose. It fills every pipeline, then holds an exact request while one pipeline pulses done. It expects a stall in that cycle and a grant of the released pipeline in the next. Random traffic also mixes done pulses with requests on every cycle. A bench model, which updates busy flags only at clock edges, judges each grant, stall and register write.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  localparam int unsigned SIG_W   = 5;
  localparam int unsigned FRAC_BITS = 23;

  // Clamp an error-significance count to the fraction width.
  function automatic logic [SIG_W-1:0] sat_count(input logic [SIG_W-1:0] n);
    if (n > SIG_W'(FRAC_BITS)) return SIG_W'(FRAC_BITS);
    return n;
  endfunction

  // Sensing-off mask: bit i set when i is below the clamped count.
  function automatic logic [FRAC_BITS-1:0] sense_mask(input logic approx,
                                                      input logic [SIG_W-1:0] n);
    logic [FRAC_BITS-1:0] m;
    logic [SIG_W-1:0]     c;
    c = sat_count(n);
    m = '0;
    for (int i = 0; i < int'(FRAC_BITS); i++) begin
      m[i] = approx && (SIG_W'(i) < c);
    end
    return m;
  endfunction

endpackage

// File: rtl/fpa_rank_sort.sv
module fpa_rank_sort #(
  parameter int unsigned NUM_PIPES = 4,
  parameter int unsigned VULN_W    = 8,
  parameter int unsigned PIPE_W    = 2
) (
  input  logic [NUM_PIPES*VULN_W-1:0] vuln_i,
  output logic [NUM_PIPES*PIPE_W-1:0] order_o
);

  logic [PIPE_W-1:0] rank [NUM_PIPES];

  // Position of each pipeline in ascending order; equal values keep index order.
  always_comb begin
    for (int p = 0; p < int'(NUM_PIPES); p++) begin
      rank[p] = '0;
      for (int q = 0; q < int'(NUM_PIPES); q++) begin
        if ((vuln_i[q*VULN_W +: VULN_W] < vuln_i[p*VULN_W +: VULN_W]) ||
            ((vuln_i[q*VULN_W +: VULN_W] == vuln_i[p*VULN_W +: VULN_W]) && (q < p)))
          rank[p] = rank[p] + PIPE_W'(1);
      end
    end
  end

  always_comb begin
    order_o = '0;
    for (int p = 0; p < int'(NUM_PIPES); p++) begin
      order_o[int'(rank[p])*PIPE_W +: PIPE_W] = PIPE_W'(p);
    end
  end

endmodule

// File: rtl/fpa_pick.sv
module fpa_pick #(
  parameter int unsigned NUM_PIPES = 4,
  parameter int unsigned PIPE_W    = 2
) (
  input  logic [NUM_PIPES*PIPE_W-1:0] order_i,
  input  logic [NUM_PIPES-1:0]        elig_i,
  output logic                        found_o,
  output logic [PIPE_W-1:0]           pick_o
);

  // Walk the order from the most error-prone slot downward so the
  // least error-prone eligible pipeline is the last one written.
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = int'(NUM_PIPES) - 1; k >= 0; k--) begin
      if (elig_i[order_i[k*PIPE_W +: PIPE_W]]) begin
        found_o = 1'b1;
        pick_o  = order_i[k*PIPE_W +: PIPE_W];
      end
    end
  end

endmodule

// File: rtl/fpa_pipe_state.sv
module fpa_pipe_state #(
  parameter int unsigned FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_hit_i,
  input  logic              done_i,
  input  logic              approx_i,
  input  logic [FRAC_W-1:0] mask_i,
  output logic              busy_o,
  output logic              cfg_approx_o,
  output logic [FRAC_W-1:0] cfg_mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o       <= 1'b0;
      cfg_approx_o <= 1'b0;
      cfg_mask_o   <= '0;
    end else if (grant_hit_i) begin
      busy_o       <= 1'b1;
      cfg_approx_o <= approx_i;
      cfg_mask_o   <= mask_i;
    end else if (done_i) begin
      busy_o       <= 1'b0;
    end
  end

endmodule

// File: rtl/fpa_alloc.sv
module fpa_alloc #(
  parameter int unsigned NUM_PIPES = 4,
  parameter int unsigned NUM_OPS   = 2,
  parameter int unsigned VULN_W    = 8,
  parameter int unsigned FRAC_W    = 23,
  localparam int unsigned PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int unsigned OP_W     = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid_i,
  input  logic [OP_W-1:0]                     req_op_i,
  input  logic                                req_approx_i,
  input  logic [4:0]                          req_sig_i,
  input  logic [VULN_W-1:0]                   err_thr_i,
  input  logic [NUM_OPS*NUM_PIPES*VULN_W-1:0] vuln_tab_i,
  input  logic [NUM_PIPES-1:0]                done_i,
  output logic                                grant_o,
  output logic [PIPE_W-1:0]                   grant_pipe_o,
  output logic                                stall_o,
  output logic [NUM_PIPES-1:0]                busy_o,
  output logic [NUM_PIPES-1:0]                cfg_approx_o,
  output logic [NUM_PIPES*FRAC_W-1:0]         cfg_mask_o
);
  import fpa_pkg::*;

  localparam int unsigned COL_W = NUM_PIPES * VULN_W;

  // Named internal events
  logic [NUM_PIPES*PIPE_W-1:0] order_by_op [NUM_OPS];
  logic [NUM_PIPES*PIPE_W-1:0] order_sel;
  logic [COL_W-1:0]            vuln_sel;
  logic [NUM_PIPES-1:0]        thr_ok;
  logic [NUM_PIPES-1:0]        elig;
  logic                        ev_found;
  logic [PIPE_W-1:0]           ev_pick;
  logic [NUM_PIPES-1:0]        grant_hit;
  logic [FRAC_W-1:0]           new_mask;

  genvar o, p;
  generate
    for (o = 0; o < int'(NUM_OPS); o++) begin : g_op
      fpa_rank_sort #(
        .NUM_PIPES (NUM_PIPES),
        .VULN_W    (VULN_W),
        .PIPE_W    (PIPE_W)
      ) u_sort (
        .vuln_i  (vuln_tab_i[o*COL_W +: COL_W]),
        .order_o (order_by_op[o])
      );
    end
  endgenerate

  always_comb begin
    order_sel = order_by_op[0];
    vuln_sel  = vuln_tab_i[0 +: COL_W];
    for (int i = 0; i < int'(NUM_OPS); i++) begin
      if (int'(req_op_i) == i) begin
        order_sel = order_by_op[i];
        vuln_sel  = vuln_tab_i[i*COL_W +: COL_W];
      end
    end
  end

  generate
    for (p = 0; p < int'(NUM_PIPES); p++) begin : g_elig
      assign thr_ok[p] = vuln_sel[p*VULN_W +: VULN_W] < err_thr_i;
      assign elig[p]   = req_valid_i && !busy_o[p] && (!req_approx_i || thr_ok[p]);
    end
  endgenerate

  fpa_pick #(
    .NUM_PIPES (NUM_PIPES),
    .PIPE_W    (PIPE_W)
  ) u_pick (
    .order_i (order_sel),
    .elig_i  (elig),
    .found_o (ev_found),
    .pick_o  (ev_pick)
  );

  assign new_mask     = FRAC_W'(sense_mask(req_approx_i, req_sig_i));
  assign grant_o      = ev_found;
  assign grant_pipe_o = ev_pick;
  assign stall_o      = req_valid_i && !ev_found;

  generate
    for (p = 0; p < int'(NUM_PIPES); p++) begin : g_pipe
      assign grant_hit[p] = ev_found && (ev_pick == PIPE_W'(p));
      fpa_pipe_state #(
        .FRAC_W (FRAC_W)
      ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant_hit_i  (grant_hit[p]),
        .done_i       (done_i[p]),
        .approx_i     (req_approx_i),
        .mask_i       (new_mask),
        .busy_o       (busy_o[p]),
        .cfg_approx_o (cfg_approx_o[p]),
        .cfg_mask_o   (cfg_mask_o[p*FRAC_W +: FRAC_W])
      );
    end
  endgenerate

endmodule

// File: rtl/fpa_alloc_chk.sv
module fpa_alloc_chk #(
  parameter int unsigned NUM_PIPES = 4,
  parameter int unsigned NUM_OPS   = 2,
  parameter int unsigned VULN_W    = 8,
  parameter int unsigned FRAC_W    = 23,
  parameter int unsigned PIPE_W    = 2,
  parameter int unsigned OP_W      = 1
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                req_valid_i,
  input logic [OP_W-1:0]                     req_op_i,
  input logic                                req_approx_i,
  input logic [4:0]                          req_sig_i,
  input logic [VULN_W-1:0]                   err_thr_i,
  input logic [NUM_OPS*NUM_PIPES*VULN_W-1:0] vuln_tab_i,
  input logic [NUM_PIPES-1:0]                done_i,
  input logic                                grant_o,
  input logic [PIPE_W-1:0]                   grant_pipe_o,
  input logic                                stall_o,
  input logic [NUM_PIPES-1:0]                busy_o,
  input logic [NUM_PIPES-1:0]                cfg_approx_o,
  input logic [NUM_PIPES*FRAC_W-1:0]         cfg_mask_o
);

  logic [VULN_W-1:0] gv;
  logic              lg_v, lg_a;
  logic [PIPE_W-1:0] lg_p;
  logic [4:0]        lg_n;
  logic [31:0]       exp_wide;

  always_comb gv = vuln_tab_i[(int'(req_op_i)*int'(NUM_PIPES) + int'(grant_pipe_o))*VULN_W +: VULN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_v <= 1'b0; lg_a <= 1'b0; lg_p <= '0; lg_n <= '0;
    end else begin
      lg_v <= grant_o; lg_a <= req_approx_i; lg_p <= grant_pipe_o; lg_n <= req_sig_i;
    end
  end

  always_comb exp_wide = lg_a ? ((32'd1 << ((lg_n > 5'd23) ? 5'd23 : lg_n)) - 32'd1) : 32'd0;

  a_r2_approx_below_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && req_approx_i) |-> (gv < err_thr_i));

  a_r4_grant_free_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> !busy_o[grant_pipe_o]);

  a_r5_stall_excludes_grant: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (req_valid_i && !grant_o));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |-> (!grant_o && !stall_o));

  a_r8_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> busy_o[$past(grant_pipe_o)]);

  a_r6_mode_written: assert property (@(posedge clk) disable iff (!rst_n)
    lg_v |-> ((cfg_approx_o[lg_p] == lg_a) &&
              (cfg_mask_o[int'(lg_p)*FRAC_W +: FRAC_W] == exp_wide[FRAC_W-1:0])));

  genvar p;
  generate
    for (p = 0; p < int'(NUM_PIPES); p++) begin : g_rel
      a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i[p] && busy_o[p]) |=> !busy_o[p]);
    end
  endgenerate

endmodule

bind fpa_alloc fpa_alloc_chk #(
  .NUM_PIPES (NUM_PIPES),
  .NUM_OPS   (NUM_OPS),
  .VULN_W    (VULN_W),
  .FRAC_W    (FRAC_W),
  .PIPE_W    (PIPE_W),
  .OP_W      (OP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_approx_i (req_approx_i),
  .req_sig_i    (req_sig_i),
  .err_thr_i    (err_thr_i),
  .vuln_tab_i   (vuln_tab_i),
  .done_i       (done_i),
  .grant_o      (grant_o),
  .grant_pipe_o (grant_pipe_o),
  .stall_o      (stall_o),
  .busy_o       (busy_o),
  .cfg_approx_o (cfg_approx_o),
  .cfg_mask_o   (cfg_mask_o)
);

// File: tb/fpa_alloc_tb.sv
module fpa_alloc_tb;
  localparam int NP = 4;
  localparam int NO = 2;
  localparam int VW = 8;
  localparam int FW = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_v = 1'b0;
  logic [0:0]        req_op = '0;
  logic              req_a = 1'b0;
  logic [4:0]        req_sig = '0;
  logic [VW-1:0]     thr = '0;
  logic [NO*NP*VW-1:0] vtab = '0;
  logic [NP-1:0]     done = '0;
  logic              grant_o, stall_o;
  logic [1:0]        grant_pipe_o;
  logic [NP-1:0]     busy_o, cfg_approx_o;
  logic [NP*FW-1:0]  cfg_mask_o;

  int checks = 0;
  int fails  = 0;

  logic [NP-1:0] mbusy = '0;
  logic [NP-1:0] mapx  = '0;
  logic [FW-1:0] mmask [NP];

  always #5 clk = ~clk;

  fpa_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_v), .req_op_i(req_op),
    .req_approx_i(req_a), .req_sig_i(req_sig), .err_thr_i(thr), .vuln_tab_i(vtab),
    .done_i(done), .grant_o(grant_o), .grant_pipe_o(grant_pipe_o), .stall_o(stall_o),
    .busy_o(busy_o), .cfg_approx_o(cfg_approx_o), .cfg_mask_o(cfg_mask_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] exp_mask(input logic a, input logic [4:0] n);
    int k;
    logic [FW-1:0] m;
    k = (int'(n) > FW) ? FW : int'(n);
    m = '0;
    if (a) for (int b = 0; b < k; b++) m = {m[FW-2:0], 1'b1};
    return m;
  endfunction

  function automatic logic [VW-1:0] vget(input int o, input int p);
    return vtab[(o*NP+p)*VW +: VW];
  endfunction

  task automatic vset(input int o, input int p, input logic [VW-1:0] v);
    vtab[(o*NP+p)*VW +: VW] = v;
  endtask

  // Inputs are set just after a falling edge; this checks them through the next rise.
  task automatic run_cycle(input string tag);
    int best;
    best = -1;
    #1;
    if (req_v)
      for (int p = 0; p < NP; p++)
        if (!mbusy[p] && (!req_a || vget(int'(req_op), p) < thr))
          if (best < 0 || vget(int'(req_op), p) < vget(int'(req_op), best)) best = p;
    chk(grant_o == (best >= 0), req_v ? (req_a ? "R2 grant" : "R3 grant") : "R10 grant",
        grant_o, best >= 0);
    chk(stall_o == (req_v && best < 0), {"R5 stall ", tag}, stall_o, req_v && best < 0);
    if (best >= 0)
      chk(grant_pipe_o == best[1:0], {"R3/R4 pipe ", tag}, grant_pipe_o, best);
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      if (best == p) begin
        mbusy[p] = 1'b1; mapx[p] = req_a; mmask[p] = exp_mask(req_a, req_sig);
      end else if (done[p]) mbusy[p] = 1'b0;
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      chk(busy_o[p] == mbusy[p], {"R8 busy ", tag}, busy_o[p], mbusy[p]);
      chk(cfg_approx_o[p] == mapx[p], {"R6/R7 mode ", tag}, cfg_approx_o[p], mapx[p]);
      chk(cfg_mask_o[p*FW +: FW] == mmask[p], {"R6/R7 mask ", tag}, cfg_mask_o[p*FW +: FW], mmask[p]);
    end
  endtask

  task automatic drive(input logic v, input int op, input logic a, input int sig,
                       input logic [NP-1:0] d, input string tag);
    @(negedge clk);
    req_v = v; req_op = op[0:0]; req_a = a; req_sig = sig[4:0]; done = d;
    run_cycle(tag);
    req_v = 1'b0; done = '0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) mmask[p] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(busy_o == '0 && cfg_approx_o == '0 && cfg_mask_o == '0, "R1 reset regs",
        {busy_o, cfg_approx_o}, 0);
    chk(!grant_o && !stall_o, "R1 reset outputs", {grant_o, stall_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 0, 1'b0, 0, '0, "R10 idle");
    drive(1'b0, 0, 1'b0, 0, '0, "R1 after release");

    // op0: 40,10,30,20 ; op1: 5,50,5,60 ; threshold 25
    vset(0,0,40); vset(0,1,10); vset(0,2,30); vset(0,3,20);
    vset(1,0,5);  vset(1,1,50); vset(1,2,5);  vset(1,3,60);
    thr = 8'd25;
    drive(1'b1, 0, 1'b0, 0, '0, "R3 exact op0");
    chk(busy_o[1], "R3 pipe1 taken first", busy_o, 4'b0010);
    drive(1'b1, 0, 1'b1, 20, '0, "R6 approx 20 bits");
    chk(cfg_mask_o[3*FW +: FW] == 23'h0FFFFF, "R6 low 20 bits off", cfg_mask_o[3*FW +: FW], 23'h0FFFFF);
    drive(1'b1, 0, 1'b1, 31, '0, "R5 no pipe below threshold");
    drive(1'b1, 1, 1'b1, 31, '0, "R6 saturate and tie");
    chk(busy_o[0] && cfg_mask_o[0 +: FW] == 23'h7FFFFF, "R6 saturated mask on pipe0",
        cfg_mask_o[0 +: FW], 23'h7FFFFF);
    drive(1'b1, 1, 1'b0, 9, '0, "R7 exact op1");
    chk(cfg_mask_o[2*FW +: FW] == '0 && !cfg_approx_o[2], "R7 exact clears mask",
        cfg_mask_o[2*FW +: FW], 0);
    // All busy: release in same cycle as request
    drive(1'b1, 1, 1'b0, 0, 4'b0100, "R9 release same cycle");
    drive(1'b1, 1, 1'b0, 0, '0, "R9 released next cycle");
    chk(busy_o == 4'b1111, "R9 pipe2 regranted", busy_o, 4'b1111);
    drive(1'b0, 0, 1'b0, 0, 4'b1111, "R8 release all");
    drive(1'b0, 0, 1'b0, 0, 4'b0101, "R8 done on free pipes");
    chk(busy_o == '0 && cfg_approx_o == 4'b1001, "R8 done on free has no effect",
        {busy_o, cfg_approx_o}, 8'b00001001);
    drive(1'b1, 0, 1'b1, 0, '0, "R6 zero count");
    drive(1'b1, 0, 1'b1, 5, 4'b0010, "R4 busy skipped");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) begin
        for (int o = 0; o < NO; o++)
          for (int p = 0; p < NP; p++) vset(o, p, 8'($urandom % 64));
        thr = 8'($urandom % 64);
      end
      drive(($urandom % 4) != 0, int'($urandom % 2), ($urandom % 2) == 1,
            int'($urandom % 32), 4'($urandom & (($urandom % 2) ? 32'hF : 32'h0)), "random");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule